// File: doc/BRIEF.md
# Reverse-Channel Parallel Port Host Receiver

This block is the host end of the reverse (peripheral-to-host) direction of an extended-capability parallel port. The peripheral offers a byte by pulling its strobe line low. The host answers on a single acknowledge line. Each byte passes through a closed four-step interlock: the strobe falls, the acknowledge rises, the strobe rises, and the acknowledge falls. Only then can the next byte start. The strobe arrives from the cable with no clock relationship to the host, so it passes through a synchroniser before the machine looks at it. The data bus is latched in the cycle in which the synchronised strobe is first seen low.

Each received byte is passed to internal logic on a valid/ready stream. A byte stays on `m_data` with `m_valid` high until a cycle in which `m_ready` is high. The receiver never raises its acknowledge while the output still holds a byte that has not been taken. A slow sink therefore holds the peripheral off at the cable instead of losing data, and no deeper buffering is needed at this edge.

If the peripheral stops partway through, the acknowledge can stay high with the strobe never returning. A programmable stall limit handles this case: after that many cycles the receiver drops the acknowledge, returns to idle and pulses an error output.

Top module: `ecp_rev_rx`

## Requirements
- R1: During reset and in the first cycle after it, `host_ack`, `m_valid` and `stall_err` are low.
- R2: `host_ack` stays low in idle, whatever the data bus does. It rises only after a synchronised falling edge of `pclk_in` (a 1-to-0 change). With an empty output slot, it rises on the (SYNC_STAGES+2)th clock edge after the edge that first samples `pclk_in` low.
- R3: The byte on `data_in` in the cycle the synchronised falling edge is detected is delivered on `m_data`, one byte per handshake, in arrival order, with none lost or duplicated.
- R4: `host_ack` is not raised in a cycle in which `m_valid` is high and `m_ready` is low. The receiver waits with `host_ack` low until the slot can take the byte.
- R5: While `host_ack` is high, once the synchronised `pclk_in` is seen high, `host_ack` goes low at the next clock edge and the receiver returns to idle. This happens SYNC_STAGES+1 edges after the edge that first samples `pclk_in` high.
- R6: With `stall_limit` nonzero, if `host_ack` has been high for `stall_limit` cycles and `pclk_in` has not returned high, `host_ack` drops and `stall_err` is high for exactly that one cycle. With `stall_limit` zero the wait never ends.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change in the next cycle.
- R8: After a stall timeout, a `pclk_in` that stays low does not start a new transfer. A new byte needs `pclk_in` to rise and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_limit | input | TMO_W | Cycles allowed with acknowledge high before giving up; 0 disables |
| pclk_in | input | 1 | Peripheral strobe, low means a byte is offered (asynchronous) |
| data_in | input | DATA_W | Parallel data bus from the peripheral |
| host_ack | output | 1 | Host acknowledge to the peripheral |
| m_valid | output | 1 | Output stream byte valid |
| m_ready | input | 1 | Output stream sink ready |
| m_data | output | DATA_W | Output stream byte |
| stall_err | output | 1 | One-cycle pulse when a stalled handshake is abandoned |

## Verification
The bench builds the block with DATA_W 8, SYNC_STAGES 3 and TMO_W 6. The deeper synchroniser makes the counted strobe-to-acknowledge latencies differ from the default, which exposes any off-by-one in the synchroniser chain. The narrow stall field keeps timeouts short, so an abandoned handshake, the low strobe that lingers after it, and the disabled-limit case (a value of 0 held for 60 cycles) all fit in a short run. A sink that is always ready, one that is held off, and one that is ready at random push the slot through its free, full and same-cycle-refill states.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_PEND = 2'd1,
    RX_ACK  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/ecp_rx_sync.sv
module ecp_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);
  logic [STAGES:0] chain;

  for (genvar i = 0; i <= STAGES; i++) begin : g_flop
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign level = chain[STAGES-1];
  assign fall  = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/ecp_rx_tmo.sv
module ecp_rx_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  assign expire = run && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
    else                     cnt <= '0;
  end
endmodule

// File: rtl/ecp_rx_slot.sv
module ecp_rx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a byte that is not taken stays put
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  stall_limit,
  input  logic              pclk_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              host_ack,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              stall_err
);
  rx_state_e         state;
  logic              pclk_lvl, pclk_fall;
  logic              slot_free, load, expire;
  logic [DATA_W-1:0] stage;

  ecp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pclk_in), .level(pclk_lvl), .fall(pclk_fall)
  );

  ecp_rx_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(state == RX_ACK), .limit(stall_limit),
    .expire(expire)
  );

  assign slot_free = !m_valid || m_ready;
  assign load      = (state == RX_PEND) && slot_free;

  ecp_rx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_data(stage),
    .out_ready(m_ready), .out_valid(m_valid), .out_data(m_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      host_ack  <= 1'b0;
      stall_err <= 1'b0;
      stage     <= '0;
    end else begin
      stall_err <= 1'b0;
      unique case (state)
        RX_IDLE: if (pclk_fall) begin
          stage <= data_in;
          state <= RX_PEND;
        end
        RX_PEND: if (slot_free) begin
          host_ack <= 1'b1;
          state    <= RX_ACK;
        end
        RX_ACK: if (pclk_lvl) begin
          host_ack <= 1'b0;
          state    <= RX_IDLE;
        end else if (expire) begin
          host_ack  <= 1'b0;
          stall_err <= 1'b1;
          state     <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R2: acknowledge only rises out of the armed state
  a_r2_rise_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> $past(state == RX_PEND));

  // R4: never acknowledge into a full, stalled slot
  a_r4_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> $past(!m_valid || m_ready));

  // R5: strobe back high releases the acknowledge
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_ACK && pclk_lvl) |=> !host_ack);

  // R6: error pulse coincides with dropping a raised acknowledge
  a_r6_err_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    stall_err |-> (!host_ack && $past(host_ack)));

  // R6: a single-cycle pulse
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall_err |=> !stall_err);
endmodule

// File: tb/sim_ecp_rev_rx.sv
`timescale 1ns/1ps
module sim_ecp_rev_rx;
  localparam int DW = 8;
  localparam int SS = 3;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] stall_limit;
  logic          pclk_in;
  logic [DW-1:0] data_in;
  logic          host_ack, m_valid, m_ready, stall_err;
  logic [DW-1:0] m_data;

  always #2 clk = ~clk;

  ecp_rev_rx #(.DATA_W(DW), .SYNC_STAGES(SS), .TMO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_limit(stall_limit), .pclk_in(pclk_in),
    .data_in(data_in), .host_ack(host_ack), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .stall_err(stall_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  int sink_mode = 0;
  logic [DW-1:0] expq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic sh[SS+1];
  int mst, mcnt;
  logic mack, mval, merr;
  logic [DW-1:0] mdat, mstg;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= SS; i++) sh[i] = 1'b1;
      mst = 0; mcnt = 0; mack = 0; mval = 0; merr = 0; mdat = '0; mstg = '0;
    end else begin
      bit fall, lvl, free, load, expire;
      int nst;
      fall   = sh[SS] && !sh[SS-1];
      lvl    = sh[SS-1];
      free   = !mval || m_ready;
      expire = (mst == 2) && (stall_limit != 0) && (mcnt == int'(stall_limit) - 1);
      merr = 0; nst = mst; load = 0;
      case (mst)
        0: if (fall) begin mstg = data_in; nst = 1; end
        1: if (free) begin mack = 1; nst = 2; load = 1; end
        default: if (lvl) begin mack = 0; nst = 0; end
                 else if (expire) begin mack = 0; nst = 0; merr = 1; end
      endcase
      mcnt = (mst == 2 && !expire) ? mcnt + 1 : 0;
      if (load) begin mval = 1; mdat = mstg; end
      else if (m_ready) mval = 0;
      mst = nst;
      for (int i = SS; i >= 1; i--) sh[i] = sh[i-1];
      sh[0] = pclk_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(host_ack == mack, "R2/R5 host_ack vs model", host_ack, mack);
      chk(m_valid == mval, "R7 m_valid vs model", m_valid, mval);
      if (mval) chk(m_data == mdat, "R3 m_data vs model", m_data, mdat);
      chk(stall_err == merr, "R6 stall_err vs model", stall_err, merr);
    end
    case (sink_mode)
      0:       m_ready = 1'b1;
      1:       m_ready = 1'b0;
      default: m_ready = 1'($urandom_range(0, 1));
    endcase
    if (rst_n && !done && m_valid && m_ready) begin
      if (expq.size() == 0) chk(1'b0, "R3 unexpected byte", m_data, -1);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(m_data == e, "R3 byte order", m_data, e);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic wait_ack(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (host_ack !== lvl && n < 400);
    if (host_ack !== lvl) chk(1'b0, "R2 handshake wait", host_ack, lvl);
  endtask

  task automatic p_send(input logic [DW-1:0] b, input int hold, input int gap);
    int n;
    @(negedge clk);
    data_in = b; pclk_in = 1'b0; expq.push_back(b);
    wait_ack(1'b1, n);
    repeat (hold) @(negedge clk);
    pclk_in = 1'b1; data_in = ~b;
    wait_ack(1'b0, n);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; pclk_in = 1'b1; data_in = '0; stall_limit = 6'd5; m_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(host_ack == 0, "R1 reset host_ack", host_ack, 0);
    chk(m_valid == 0, "R1 reset m_valid", m_valid, 0);
    chk(stall_err == 0, "R1 reset stall_err", stall_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ack == 0 && m_valid == 0, "R1 after reset", host_ack, 0);

    // R2: idle with data toggling, no acknowledge
    for (int i = 0; i < 10; i++) begin
      data_in = DW'(i * 37);
      @(negedge clk);
      chk(host_ack == 0, "R2 idle ack low", host_ack, 0);
    end

    // R2 latency, R5 release latency
    data_in = 8'h5A; pclk_in = 1'b0; expq.push_back(8'h5A);
    wait_ack(1'b1, n);
    chk(n == SS + 2, "R2 ack latency", n, SS + 2);
    pclk_in = 1'b1; data_in = 8'hFF;
    wait_ack(1'b0, n);
    chk(n == SS + 1, "R5 release latency", n, SS + 1);
    repeat (3) @(negedge clk);

    // R4 / R7: sink blocked
    sink_mode = 1;
    p_send(8'h11, 1, 2);
    @(negedge clk);
    data_in = 8'h22; pclk_in = 1'b0; expq.push_back(8'h22);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(host_ack == 0, "R4 ack held while slot full", host_ack, 0);
      chk(m_valid == 1 && m_data == 8'h11, "R7 byte held", m_data, 8'h11);
    end
    sink_mode = 0;
    wait_ack(1'b1, n);
    pclk_in = 1'b1; data_in = 8'h00;
    wait_ack(1'b0, n);
    repeat (3) @(negedge clk);

    // R6 timeout, R8 lingering low strobe
    stall_limit = 6'd5;
    data_in = 8'hC3; pclk_in = 1'b0; expq.push_back(8'hC3);
    wait_ack(1'b1, n);
    n = 0;
    while (host_ack && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 5, "R6 ack high cycles before timeout", n, 5);
    chk(stall_err == 1, "R6 error pulse", stall_err, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(host_ack == 0, "R8 no restart on lingering low", host_ack, 0);
    end
    pclk_in = 1'b1;
    repeat (6) @(negedge clk);
    p_send(8'h3C, 0, 2);

    // R6 disabled limit
    stall_limit = '0;
    data_in = 8'h96; pclk_in = 1'b0; expq.push_back(8'h96);
    wait_ack(1'b1, n);
    repeat (60) @(negedge clk);
    chk(host_ack == 1, "R6 disabled limit keeps ack", host_ack, 1);
    chk(stall_err == 0, "R6 disabled limit no error", stall_err, 0);
    pclk_in = 1'b1;
    wait_ack(1'b0, n);

    // random traffic with random back-pressure
    stall_limit = 6'd40;
    sink_mode = 2;
    for (int i = 0; i < 30; i++)
      p_send(DW'($urandom), $urandom_range(0, 3), $urandom_range(0, 3));

    sink_mode = 0;
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R3 all bytes delivered", expq.size(), 0);
    finish_run();
  end
endmodule